// File: doc/BRIEF.md
# DMA descriptor chain walker

This block drives a data mover from a chain of descriptors held in memory. Each descriptor occupies eight 32-bit words. The block reads the words one at a time through a simple read port. It then presents the buffer address and length of the descriptor to the data mover, together with the packet-boundary flags and the low application bits of the descriptor. When the data mover reports completion, the block takes the address of the next descriptor from the link word. It never computes that address by incrementing.

Software controls the walk through two pointers. The current pointer names the descriptor to start from. The tail pointer names the last descriptor that is ready. A walk ends after the descriptor at the tail address has completed. Because the tail can be moved forward at any time, descriptors can form a ring that software keeps extending while transfers run. After a walk ends, the current pointer holds the link of the last completed descriptor, so a later tail write resumes from that point. A misaligned pointer or an empty buffer stops the block in a sticky error state.

Top module: `chain_walker`

## Requirements
- R1: Descriptor word layout, by byte offset from the descriptor base: 0 link, 4 buffer address, 8 buffer length, 12 status/control, 16 to 28 application words 1 to 4. A transfer presents the buffer address as `xfer_addr` and the buffer length as `xfer_len`.
- R2: Only one memory read is outstanding at a time. A new `mem_req` is issued only after the previous read has returned with `mem_rvalid`. The eight words are read at offsets 0, 4, ... 28 in that order. `xfer_req` rises only after all eight words have arrived.
- R3: The address of the next descriptor is always the value of the link word, including when descriptors sit at neighbouring addresses.
- R4: The walk stops, with `idle` high, after completing the descriptor whose base address equals the tail pointer. Every descriptor before it is transferred in link order.
- R5: Control-word bit 27 appears as `xfer_sop` and bit 26 appears as `xfer_eop`. Bits 23:0 appear unchanged on `xfer_app`. All other control bits have no effect.
- R6: A tail write in the idle state, with no error, starts a walk at the current pointer. After a walk, the current pointer equals the link of the last completed descriptor.
- R7: A tail write during a walk only moves the stopping point. This includes a write in the same cycle as the `xfer_done` of the old tail descriptor.
- R8: A current-pointer write is accepted only in the idle state and is ignored during a walk. Writing both pointers in the same idle cycle starts the walk at the written current pointer.
- R9: A descriptor pointer (start pointer or link) with any of bits 4:0 set raises `err`, and no memory read is issued for it.
- R10: A descriptor whose length word is zero raises `err`, and no transfer request is made for it.
- R11: `err` stays high until reset. While it is high, pointer writes start nothing.
- R12: `idle` is low while a descriptor is being fetched or transferred. After reset, `idle`=1, `err`=0, and `mem_req` and `xfer_req` are both low.
- R13: `xfer_req` and its fields stay stable until `xfer_done` is sampled high. `xfer_req` drops in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_wr | input | 1 | Write strobe for the current pointer |
| cur_wdata | input | 32 | New current pointer (byte address) |
| tail_wr | input | 1 | Write strobe for the tail pointer |
| tail_wdata | input | 32 | New tail pointer (byte address) |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid, at least one cycle after the request |
| mem_rdata | input | 32 | Read data |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_addr | output | 32 | Buffer address of the transfer |
| xfer_len | output | 32 | Buffer length of the transfer |
| xfer_sop | output | 1 | Start-of-packet flag of the descriptor |
| xfer_eop | output | 1 | End-of-packet flag of the descriptor |
| xfer_app | output | 24 | Application bits from the control word |
| xfer_done | input | 1 | Data mover completion pulse |
| idle | output | 1 | No descriptor is being fetched or transferred |
| err | output | 1 | Sticky error: misaligned pointer or zero length |

## Verification
The hardest case to reach from the ports is a tail write that arrives in exactly the cycle when the old tail descriptor completes. If the write is missed there, the walk ends early. The bench watches `xfer_done` at the falling edge and drives the tail write so that the same rising edge samples both signals. It then confirms that the extra descriptor is transferred. The bench also places descriptors at scrambled ring addresses, so that some neighbours in memory are not neighbours in the chain. It then sweeps every start position and chain length under varying memory and transfer latencies.

// File: rtl/chain_walker_pkg.sv
`timescale 1ns/1ps
package chain_walker_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 8;
  localparam int DESC_BYTES = DESC_WORDS * WORD_W / 8;
  localparam int ALIGN_W    = $clog2(DESC_BYTES);
  localparam int KEEP_WORDS = 4;
  localparam int W_LINK     = 0;
  localparam int W_BUF      = 1;
  localparam int W_LEN      = 2;
  localparam int W_CTRL     = 3;
  localparam int SOP_BIT    = 27;
  localparam int EOP_BIT    = 26;
  localparam int APP_W      = 24;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2,
    ST_HALT  = 2'd3
  } walk_st_t;
endpackage

// File: rtl/cw_fetch.sv
`timescale 1ns/1ps
// Reads one descriptor, one word at a time, and keeps its leading words.
module cw_fetch #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 8,
  parameter int KEEP   = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [WORD_W-1:0]           start_ptr,
  output logic                        mem_req,
  output logic [WORD_W-1:0]           mem_addr,
  input  logic                        mem_rvalid,
  input  logic [WORD_W-1:0]           mem_rdata,
  output logic                        done,
  output logic [KEEP-1:0][WORD_W-1:0] words
);
  localparam int IDX_W   = $clog2(NWORDS);
  localparam int BYTE_SH = $clog2(WORD_W / 8);
  localparam int BASE_AL = $clog2(NWORDS * WORD_W / 8);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] base;
  logic              busy;

  assign mem_addr = base + (WORD_W'(idx) << BYTE_SH);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      base    <= '0;
      busy    <= 1'b0;
      mem_req <= 1'b0;
      done    <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      if (start) begin
        base    <= start_ptr;
        idx     <= '0;
        busy    <= 1'b1;
        mem_req <= 1'b1;
      end else if (busy && mem_rvalid) begin
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx     <= idx + 1'b1;
          mem_req <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      words <= '0;
    end else if (busy && mem_rvalid) begin
      for (int i = 0; i < KEEP; i++) begin
        if (idx == IDX_W'(i)) words[i] <= mem_rdata;
      end
    end
  end

  // A second request never directly follows a request (R2)
  assert_one_read_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  // The first word of a descriptor is read from an aligned base (R9)
  assert_base_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && idx == '0) |-> (mem_addr[BASE_AL-1:0] == '0));
  // Completion only follows a returned read (R2)
  assert_done_after_data_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_rvalid));
endmodule

// File: rtl/cw_regs.sv
`timescale 1ns/1ps
// Current and tail pointers, with the launch pointer and the tail comparison.
module cw_regs #(
  parameter int AW      = 32,
  parameter int ALIGN_W = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_ok,
  input  logic          cur_wr,
  input  logic [AW-1:0] cur_wdata,
  input  logic          tail_wr,
  input  logic [AW-1:0] tail_wdata,
  input  logic          adv,
  input  logic [AW-1:0] adv_ptr,
  output logic [AW-1:0] launch_ptr,
  output logic          launch_aligned,
  output logic          at_tail
);
  logic [AW-1:0] cur_q;
  logic [AW-1:0] tail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      tail_q <= '0;
    end else begin
      if (adv)                  cur_q <= adv_ptr;
      else if (sw_ok && cur_wr) cur_q <= cur_wdata;
      if (tail_wr) tail_q <= tail_wdata;
    end
  end

  assign launch_ptr     = (sw_ok && cur_wr) ? cur_wdata : cur_q;
  assign launch_aligned = (launch_ptr[ALIGN_W-1:0] == '0);
  assign at_tail        = (cur_q == (tail_wr ? tail_wdata : tail_q));

  // The current pointer moves only on completion or on an idle write (R8)
  assert_cur_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (!sw_ok && !adv) |=> $stable(cur_q));
  // A completion loads the link pointer (R6)
  assert_cur_follows_link_R6: assert property (@(posedge clk) disable iff (rst)
    adv |=> (cur_q == $past(adv_ptr)));
endmodule

// File: rtl/chain_walker.sv
`timescale 1ns/1ps
module chain_walker
  import chain_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cur_wr,
  input  logic [WORD_W-1:0] cur_wdata,
  input  logic              tail_wr,
  input  logic [WORD_W-1:0] tail_wdata,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              xfer_req,
  output logic [WORD_W-1:0] xfer_addr,
  output logic [WORD_W-1:0] xfer_len,
  output logic              xfer_sop,
  output logic              xfer_eop,
  output logic [APP_W-1:0]  xfer_app,
  input  logic              xfer_done,
  output logic              idle,
  output logic              err
);
  walk_st_t st;

  logic                              f_start;
  logic                              f_done;
  logic [WORD_W-1:0]                 f_ptr;
  logic [KEEP_WORDS-1:0][WORD_W-1:0] w;
  logic                              sw_ok;
  logic                              adv;
  logic                              launch_aligned;
  logic                              at_tail;
  logic [WORD_W-1:0]                 launch_ptr;
  logic [WORD_W-1:0]                 link_w;
  logic [WORD_W-1:0]                 ctrl_w;
  logic                              link_ok;
  logic                              unused_ctrl_bits;

  assign link_w  = w[W_LINK];
  assign ctrl_w  = w[W_CTRL];
  assign link_ok = (link_w[ALIGN_W-1:0] == '0);
  assign sw_ok   = (st == ST_IDLE);
  assign idle    = (st == ST_IDLE) || (st == ST_HALT);
  assign err     = (st == ST_HALT);
  assign unused_ctrl_bits = ^{ctrl_w[WORD_W-1:SOP_BIT+1], ctrl_w[EOP_BIT-1:APP_W]};

  cw_regs #(.AW(WORD_W), .ALIGN_W(ALIGN_W)) u_regs (
    .clk            (clk),
    .rst            (rst),
    .sw_ok          (sw_ok),
    .cur_wr         (cur_wr),
    .cur_wdata      (cur_wdata),
    .tail_wr        (tail_wr),
    .tail_wdata     (tail_wdata),
    .adv            (adv),
    .adv_ptr        (link_w),
    .launch_ptr     (launch_ptr),
    .launch_aligned (launch_aligned),
    .at_tail        (at_tail)
  );

  cw_fetch #(.WORD_W(WORD_W), .NWORDS(DESC_WORDS), .KEEP(KEEP_WORDS)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .start      (f_start),
    .start_ptr  (f_ptr),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .done       (f_done),
    .words      (w)
  );

  always_comb begin
    f_start = 1'b0;
    f_ptr   = launch_ptr;
    adv     = 1'b0;
    unique case (st)
      ST_IDLE: if (tail_wr && launch_aligned) f_start = 1'b1;
      ST_XFER: if (xfer_done) begin
        adv = 1'b1;
        if (!at_tail && link_ok) begin
          f_start = 1'b1;
          f_ptr   = link_w;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      xfer_req  <= 1'b0;
      xfer_addr <= '0;
      xfer_len  <= '0;
      xfer_sop  <= 1'b0;
      xfer_eop  <= 1'b0;
      xfer_app  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (tail_wr) st <= launch_aligned ? ST_FETCH : ST_HALT;
        ST_FETCH: if (f_done) begin
          if (w[W_LEN] == '0) begin
            st <= ST_HALT;
          end else begin
            st        <= ST_XFER;
            xfer_req  <= 1'b1;
            xfer_addr <= w[W_BUF];
            xfer_len  <= w[W_LEN];
            xfer_sop  <= ctrl_w[SOP_BIT];
            xfer_eop  <= ctrl_w[EOP_BIT];
            xfer_app  <= ctrl_w[APP_W-1:0];
          end
        end
        ST_XFER: if (xfer_done) begin
          xfer_req <= 1'b0;
          if (at_tail)      st <= ST_IDLE;
          else if (link_ok) st <= ST_FETCH;
          else              st <= ST_HALT;
        end
        default: st <= ST_HALT;
      endcase
    end
  end

  // No activity toward memory or the data mover while idle (R12)
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    idle |-> (!mem_req && !xfer_req));
  // The request and its fields hold until completion (R13)
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_len)
                                  && $stable(xfer_app)));
  // The request drops right after completion (R13)
  assert_req_release_R13: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && xfer_done) |=> !xfer_req);
  // An empty buffer is never handed to the data mover (R10)
  assert_len_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> (xfer_len != '0));
  // The error state holds until reset (R11)
  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: tb/chain_walker_test.sv
`timescale 1ns/1ps
module chain_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cur_wr = 1'b0, tail_wr = 1'b0;
  logic [31:0] cur_wdata = '0, tail_wdata = '0;
  logic        mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        xfer_req, xfer_sop, xfer_eop, xfer_done;
  logic [31:0] xfer_addr, xfer_len;
  logic [23:0] xfer_app;
  logic        idle, err;

  always #4 clk = ~clk;

  chain_walker uut (
    .clk(clk), .rst(rst), .cur_wr(cur_wr), .cur_wdata(cur_wdata),
    .tail_wr(tail_wr), .tail_wdata(tail_wdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_sop(xfer_sop), .xfer_eop(xfer_eop), .xfer_app(xfer_app),
    .xfer_done(xfer_done), .idle(idle), .err(err)
  );

  int errors = 0, checks = 0;
  int mem_lat = 1, xfer_lat = 1;
  logic [31:0] mem [64];

  // transfer log
  logic [31:0] lg_addr [64];
  logic [31:0] lg_len  [64];
  logic        lg_sop  [64];
  logic        lg_eop  [64];
  logic [23:0] lg_app  [64];
  int log_n = 0;

  int nreq = 0, wi = 0, rv_cnt = 0;
  int out_viol = 0, order_viol = 0, fetch_viol = 0, hold_viol = 0, idle_viol = 0;

  // descriptor k lives at a scrambled ring slot
  function automatic logic [31:0] daddr(input int k);
    return 32'(32 * ((5 * (k % 8) + 2) % 8));
  endfunction
  function automatic logic [31:0] dbuf(input int k);
    return 32'h1000_0000 + 32'((k % 8) * 32'h340);
  endfunction
  function automatic logic [31:0] dlen(input int k);
    return 32'(16 * ((k % 8) + 1) + 3);
  endfunction
  function automatic logic dsop(input int k);
    return ((k % 8) % 3) == 0;
  endfunction
  function automatic logic deop(input int k);
    return (((k % 8) % 3) == 2) || ((k % 8) == 7);
  endfunction
  function automatic logic [23:0] dapp(input int k);
    return 24'((k % 8) * 24'h13579 + 24'h0A0B0C);
  endfunction

  task automatic init_mem();
    for (int k = 0; k < 8; k++) begin
      int b;
      b = int'(daddr(k)) / 4;
      mem[b + 0] = daddr(k + 1);
      mem[b + 1] = dbuf(k);
      mem[b + 2] = dlen(k);
      // bits 31:28 and 25:24 carry noise that must not matter (R5)
      mem[b + 3] = {4'hA, dsop(k), deop(k), 2'b11, dapp(k)};
      for (int j = 4; j < 8; j++) mem[b + j] = 32'hC0DE_0000 + 32'(k * 16 + j);
    end
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: one request, data after mem_lat cycles
  logic        pend = 1'b0;
  int          dly = 0;
  logic [31:0] raddr = '0;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst) begin
      pend <= 1'b0;
      wi = 0;
    end else if (mem_req) begin
      nreq++;
      if (pend) out_viol++;
      if (mem_addr[4:0] != 5'(wi * 4)) order_viol++;
      if (wi == 0) rv_cnt = 0;
      wi = (wi + 1) % 8;
      pend  <= 1'b1;
      dly   <= mem_lat;
      raddr <= mem_addr;
    end else if (pend) begin
      if (dly <= 1) begin
        pend       <= 1'b0;
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[raddr[7:2]];
        rv_cnt++;
      end else begin
        dly <= dly - 1;
      end
    end
  end

  // data mover model
  logic        xseen = 1'b0, drop_chk = 1'b0;
  int          xcnt = 0;
  logic [31:0] h_addr = '0, h_len = '0;
  always @(posedge clk) begin
    xfer_done <= 1'b0;
    drop_chk  <= 1'b0;
    if (rst) begin
      xseen <= 1'b0;
    end else begin
      if (drop_chk && xfer_req) hold_viol++;
      if (xfer_done) drop_chk <= 1'b1;
      if (xseen) begin
        if (!xfer_req || xfer_addr != h_addr || xfer_len != h_len) hold_viol++;
        if (xcnt <= 1) begin
          xseen     <= 1'b0;
          xfer_done <= 1'b1;
        end else begin
          xcnt <= xcnt - 1;
        end
      end else if (xfer_req && !xfer_done) begin
        if (rv_cnt != 8) fetch_viol++;
        if (log_n < 64) begin
          lg_addr[log_n] = xfer_addr;
          lg_len[log_n]  = xfer_len;
          lg_sop[log_n]  = xfer_sop;
          lg_eop[log_n]  = xfer_eop;
          lg_app[log_n]  = xfer_app;
        end
        log_n++;
        xseen  <= 1'b1;
        xcnt   <= xfer_lat;
        h_addr <= xfer_addr;
        h_len  <= xfer_len;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && idle && (mem_req || xfer_req || pend || xseen)) idle_viol++;
  end

  task automatic reset_dut();
    rst = 1'b1;
    cur_wr = 1'b0;
    tail_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    log_n = 0;
    @(negedge clk);
  endtask

  task automatic write_cur(input logic [31:0] v);
    cur_wr = 1'b1; cur_wdata = v;
    @(negedge clk);
    cur_wr = 1'b0;
  endtask

  task automatic write_tail(input logic [31:0] v);
    tail_wr = 1'b1; tail_wdata = v;
    @(negedge clk);
    tail_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (idle) break;
    end
  endtask

  task automatic expect_walk(input int k0, input int n, input string tag);
    chk(log_n == n, {tag, " R4 transfer count"}, log_n, n);
    for (int j = 0; j < n && j < log_n; j++) begin
      bit ok;
      ok = lg_addr[j] == dbuf(k0 + j) && lg_len[j] == dlen(k0 + j) &&
           lg_sop[j] == dsop(k0 + j) && lg_eop[j] == deop(k0 + j) &&
           lg_app[j] == dapp(k0 + j);
      chk(ok, {tag, " R1 R3 R5 transfer fields"}, lg_addr[j], dbuf(k0 + j));
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R4: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int n0;
    init_mem();
    reset_dut();
    // R12 reset state
    chk(idle == 1'b1, "R12 reset idle", idle, 1);
    chk(err == 1'b0, "R12 reset err", err, 0);
    chk(!mem_req && !xfer_req, "R12 reset requests", {mem_req, xfer_req}, 0);

    // sweep every start slot and chain length (R1 R3 R4 R5 R6)
    for (int s = 0; s < 8; s++) begin
      for (int n = 1; n <= 8; n++) begin
        mem_lat  = ((s + n) % 3) + 1;
        xfer_lat = ((s * n) % 2) + 1;
        log_n = 0;
        write_cur(daddr(s));
        write_tail(daddr(s + n - 1));
        chk(!idle, "R12 busy after start", idle, 0);
        wait_idle();
        expect_walk(s, n, "sweep");
        chk(idle && !err, "R4 stopped cleanly", {idle, err}, 2);
      end
    end

    // R6 resume: last sweep walk ended at slot 6, so current is slot 7
    log_n = 0;
    write_tail(daddr(9));
    wait_idle();
    expect_walk(7, 3, "R6 resume");

    // R8 both pointers written together while idle
    log_n = 0;
    cur_wr = 1'b1; cur_wdata = daddr(3);
    write_tail(daddr(3));
    wait_idle();
    expect_walk(3, 1, "R8 joint write");

    // R8 current write during a walk is ignored
    log_n = 0;
    write_cur(daddr(0));
    write_tail(daddr(2));
    repeat (5) @(negedge clk);
    write_cur(daddr(5));
    wait_idle();
    expect_walk(0, 3, "R8 busy write");
    log_n = 0;
    write_tail(daddr(3));
    wait_idle();
    expect_walk(3, 1, "R8 resume after ignored write");

    // R7 extend tail while fetching
    log_n = 0;
    mem_lat = 2;
    write_cur(daddr(4));
    write_tail(daddr(4));
    repeat (4) @(negedge clk);
    write_tail(daddr(6));
    wait_idle();
    expect_walk(4, 3, "R7 extend");

    // R7 tail write in the completion cycle of the old tail
    log_n = 0;
    write_cur(daddr(1));
    write_tail(daddr(1));
    for (int i = 0; i < 2000; i++) begin
      if (xfer_done) break;
      @(negedge clk);
    end
    write_tail(daddr(2));
    wait_idle();
    expect_walk(1, 2, "R7 same-cycle extend");

    // R9 misaligned start pointer
    reset_dut();
    n0 = nreq;
    write_cur(daddr(0) + 32'd8);
    write_tail(daddr(0));
    repeat (20) @(negedge clk);
    chk(err == 1'b1, "R9 misaligned start err", err, 1);
    chk(idle == 1'b1, "R9 halted idle", idle, 1);
    chk(nreq == n0, "R9 no read issued", nreq - n0, 0);
    chk(log_n == 0, "R9 no transfer", log_n, 0);
    // R11 writes while in error start nothing
    write_cur(daddr(0));
    write_tail(daddr(0));
    repeat (30) @(negedge clk);
    chk(err == 1'b1, "R11 err sticky", err, 1);
    chk(nreq == n0 && log_n == 0, "R11 no activity in error", nreq - n0, 0);

    // R11 reset clears error and walking works again
    reset_dut();
    chk(err == 1'b0, "R11 reset clears err", err, 0);
    write_cur(daddr(2));
    write_tail(daddr(3));
    wait_idle();
    expect_walk(2, 2, "R11 after reset");

    // R9 misaligned link word
    reset_dut();
    mem[int'(daddr(0)) / 4] = daddr(1) + 32'd4;
    n0 = nreq;
    write_cur(daddr(0));
    write_tail(daddr(2));
    wait_idle();
    chk(log_n == 1, "R9 link halt transfers", log_n, 1);
    chk(err == 1'b1, "R9 link err", err, 1);
    chk(nreq - n0 == 8, "R9 no fetch of bad link", nreq - n0, 8);
    init_mem();

    // R10 zero length
    reset_dut();
    mem[int'(daddr(1)) / 4 + 2] = 32'd0;
    n0 = nreq;
    write_cur(daddr(0));
    write_tail(daddr(3));
    wait_idle();
    expect_walk(0, 1, "R10 zero length");
    chk(err == 1'b1, "R10 err", err, 1);
    chk(nreq - n0 == 16, "R10 reads before halt", nreq - n0, 16);
    init_mem();

    // protocol monitors
    chk(out_viol == 0, "R2 one outstanding read", out_viol, 0);
    chk(order_viol == 0, "R2 word order", order_viol, 0);
    chk(fetch_viol == 0, "R2 transfer after eight words", fetch_viol, 0);
    chk(hold_viol == 0, "R13 request hold and release", hold_viol, 0);
    chk(idle_viol == 0, "R12 idle while active", idle_viol, 0);

    summary();
    $finish;
  end
endmodule